// File: doc/BRIEF.md
# Banked GPIO Register Controller

The controller holds the configuration and data registers for up to five banks of 32 general-purpose pins. Software reaches it over a plain byte-addressed register bus that carries read and write strobes, an address, write data and read data. Each bank has four things: a direction word, an output latch, two atomic update ports and a synchronized view of the pin levels. The update ports set or clear chosen latch bits in one write, with no read-modify-write sequence.

Toward the pads, each bank drives a 32-bit output value and a 32-bit output enable, and it receives 32 raw input levels. The direction word decides which pins are driven. The input view always shows the pad level, and it lags the pad by the depth of a two-stage synchronizer. Interrupt edge detection belongs to a neighbouring block. The interrupt words inside each bank block are therefore left unmapped here.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: When reset is released, every direction bit is 1, so no pin is driven (`pin_oe` all zero). Every output-latch bit is 0.
- R2: A pin's output enable is 1 exactly when its direction bit is 0. A write to the direction word replaces it, and a read returns it.
- R3: A write to the output-data word replaces the bank's latch. `pin_out` shows the latch from the cycle after the write, and a read of the output-data word returns the latch.
- R4: A write to the set port turns on every latch bit whose write-data bit is 1. All other bits stay as they were, so writing zero changes nothing.
- R5: A write to the clear port turns off every latch bit whose write-data bit is 1. All other bits stay as they were.
- R6: A read of the set port or of the clear port returns the current latch value.
- R7: A read of the input-data word returns the pin levels, including those of pins driven as outputs. The levels pass through two flip-flop stages. A level applied before clock edge k is returned by a read issued after edge k+1, and a read issued between edge k and edge k+1 still returns the old level.
- R8: Bank b occupies byte addresses 0x10 + 0x28*b onward. Within the block the words are direction at +0x00, output data at +0x04, set at +0x08, clear at +0x0C and input data at +0x10. A write to one bank leaves every other bank unchanged.
- R9: The following accesses read as zero and their writes change nothing: addresses below 0x10, the words +0x14 to +0x24 of a block, addresses not on a 4-byte boundary, and banks at or beyond `NUM_BANKS`.
- R10: Read data is combinational in the cycle the read strobe is high. A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading or unmapped |
| pin_out | output | NUM_BANKS*32 | Output value per pin, bank b in bits [32b+31:32b] |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin |
| pin_in | input | NUM_BANKS*32 | Raw pad level per pin |

## Verification
Two functions can land in the same cycle: a register read and an update of that same register. The bench provokes this by raising both strobes in one cycle at the output word of one bank. It expects the read to return the value held before the write, and it expects a later read to return the new value. A second overlap comes from pin activity and the synchronizer. The bench changes a bank's pin levels in the same cycle as a read of that bank's input word, then reads again on each of the next two cycles, and expects the old level twice before the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned GPIO_W     = 32;
  localparam int unsigned MAX_BANKS  = 5;
  localparam int unsigned BLK_BASE   = 32'h10;
  localparam int unsigned BLK_STRIDE = 32'h28;
  localparam int unsigned BANK_W     = $clog2(MAX_BANKS + 1);

  // Word order inside a bank block; the position is the word index.
  typedef enum logic [2:0] {
    RG_DIR  = 3'd0,
    RG_OUT  = 3'd1,
    RG_SET  = 3'd2,
    RG_CLR  = 3'd3,
    RG_IN   = 3'd4,
    RG_NONE = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic              hit;
    logic [BANK_W-1:0] bank;
    reg_sel_e          sel;
  } dec_t;

  // Address arithmetic: base, stride, word index and alignment.
  function automatic dec_t decode_addr(input int unsigned a, input int unsigned nb);
    dec_t        d;
    int unsigned off;
    int unsigned bk;
    int unsigned wd;
    d.hit  = 1'b0;
    d.bank = '0;
    d.sel  = RG_NONE;
    if (a >= BLK_BASE) begin
      off = a - BLK_BASE;
      bk  = off / BLK_STRIDE;
      wd  = off % BLK_STRIDE;
      if ((bk < nb) && ((wd % 4) == 0) && ((wd / 4) <= 4)) begin
        d.hit  = 1'b1;
        d.bank = BANK_W'(bk);
        d.sel  = reg_sel_e'(3'(wd / 4));
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [NUM_BANKS-1:0] bank_oh,
  output reg_sel_e             sel
);

  dec_t dec_w;

  assign dec_w = decode_addr(32'(addr), NUM_BANKS);
  assign hit   = dec_w.hit;
  assign sel   = dec_w.sel;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_oh
    assign bank_oh[b] = dec_w.hit && (dec_w.bank == BANK_W'(b));
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [GPIO_W-1:0] wdata,
  output logic [GPIO_W-1:0] dir_q,
  output logic [GPIO_W-1:0] lat_q
);

  logic dir_wr;
  logic out_wr;
  logic set_wr;
  logic clr_wr;

  assign dir_wr = wr_en && (sel == RG_DIR);
  assign out_wr = wr_en && (sel == RG_OUT);
  assign set_wr = wr_en && (sel == RG_SET);
  assign clr_wr = wr_en && (sel == RG_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
    end else if (dir_wr) begin
      dir_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (out_wr) begin
      lat_q <= wdata;
    end else if (set_wr) begin
      lat_q <= lat_q | wdata;
    end else if (clr_wr) begin
      lat_q <= lat_q & ~wdata;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [GPIO_W-1:0]           bus_wdata,
  output logic [GPIO_W-1:0]           bus_rdata,
  output logic [NUM_BANKS*GPIO_W-1:0] pin_out,
  output logic [NUM_BANKS*GPIO_W-1:0] pin_oe,
  input  logic [NUM_BANKS*GPIO_W-1:0] pin_in
);

  localparam int unsigned PW = NUM_BANKS * GPIO_W;

  logic                 acc_hit;
  logic [NUM_BANKS-1:0] acc_bank_oh;
  reg_sel_e             acc_sel;
  logic [PW-1:0]        in_sync;
  logic [GPIO_W-1:0]    dir_w [NUM_BANKS];
  logic [GPIO_W-1:0]    lat_w [NUM_BANKS];
  logic [GPIO_W-1:0]    rd_word;

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .addr    (bus_addr),
    .hit     (acc_hit),
    .bank_oh (acc_bank_oh),
    .sel     (acc_sel)
  );

  gpio_in_sync #(.WIDTH(PW)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pin_in),
    .sync_out (in_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && acc_bank_oh[b];

    gpio_bank_regs regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bank_wr),
      .sel   (acc_sel),
      .wdata (bus_wdata),
      .dir_q (dir_w[b]),
      .lat_q (lat_w[b])
    );

    assign pin_out[b*GPIO_W +: GPIO_W] = lat_w[b];
    assign pin_oe[b*GPIO_W +: GPIO_W]  = ~dir_w[b];
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc_bank_oh[b]) begin
        case (acc_sel)
          RG_DIR:                 rd_word = dir_w[b];
          RG_OUT, RG_SET, RG_CLR: rd_word = lat_w[b];
          RG_IN:                  rd_word = in_sync[b*GPIO_W +: GPIO_W];
          default:                rd_word = '0;
        endcase
      end
    end
  end

  assign bus_rdata = (bus_rd && acc_hit) ? rd_word : '0;

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [GPIO_W-1:0]           bus_wdata,
  input logic [GPIO_W-1:0]           bus_rdata,
  input logic [NUM_BANKS*GPIO_W-1:0] pin_out,
  input logic [NUM_BANKS*GPIO_W-1:0] pin_oe,
  input logic [NUM_BANKS*GPIO_W-1:0] pin_in
);

  localparam int unsigned PW = NUM_BANKS * GPIO_W;
  localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BLK_BASE + 32'h00);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BLK_BASE + 32'h08);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BLK_BASE + 32'h0C);
  localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(BLK_BASE + 32'h10);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(BLK_BASE);

  logic [1:0] since_rst;
  wire        unused_bits = ^{pin_in[PW-1:GPIO_W], pin_oe[PW-1:GPIO_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0) && (pin_out == '0));

  // R2
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DIR0) |-> bus_rdata == ~pin_oe[GPIO_W-1:0]);

  // R4
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET0) |=>
      pin_out == ($past(pin_out) | PW'($past(bus_wdata))));

  // R5
  clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR0) |=>
      pin_out == ($past(pin_out) & ~PW'($past(bus_wdata))));

  // R7
  in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && bus_rd && bus_addr == A_IN0) |->
      bus_rdata == $past(pin_in[GPIO_W-1:0], 2));

  // R9
  low_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < A_LOW) |-> bus_rdata == '0);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_banked_ctrl gpio_banked_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_in    (pin_in)
);

// File: tb/gpio_banked_ctrl_tb_top.sv
module gpio_banked_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int NB    = 5;
  localparam int AW    = 8;
  localparam int PW    = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [PW-1:0] pin_out;
  logic [PW-1:0] pin_oe;
  logic [PW-1:0] pin_in = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] dir_m [NB];
  logic [31:0] lat_m [NB];
  logic [31:0] in_m  [NB];

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  gpio_banked_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  function automatic int addr_of(int bank, int word);
    return 16 + 40 * bank + 4 * word;
  endfunction

  // Bench view of the map: returns bank, word, or -1 when unmapped.
  function automatic void map_of(int a, output int bank, output int word);
    int off;
    bank = -1;
    word = -1;
    if (a >= 16) begin
      off = a - 16;
      if ((off / 40) < NB && (off % 40) % 4 == 0 && (off % 40) / 4 <= 4) begin
        bank = off / 40;
        word = (off % 40) / 4;
      end
    end
  endfunction

  function automatic logic [31:0] exp_read(int a);
    int bk;
    int wd;
    map_of(a, bk, wd);
    if (bk < 0) return 32'h0;
    case (wd)
      0:       return dir_m[bk];
      4:       return in_m[bk];
      default: return lat_m[bk];
    endcase
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    int bk;
    int wd;
    map_of(a, bk, wd);
    if (bk >= 0) begin
      case (wd)
        0: dir_m[bk] = d;
        1: lat_m[bk] = d;
        2: lat_m[bk] = lat_m[bk] | d;
        3: lat_m[bk] = lat_m[bk] & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, expected read data pushed before the model sees the write.
  task automatic bus_op(bit wr, bit rd, int a, logic [31:0] d, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = AW'(a);
    bus_wdata = d;
    if (rd) begin
      e.v   = exp_read(a);
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (wr) model_write(a, d);
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic chk_pins(string tag);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      chk({tag, " pin_out"}, pin_out[b*32 +: 32], lat_m[b]);
      chk({tag, " pin_oe"},  pin_oe[b*32 +: 32],  ~dir_m[b]);
    end
  endtask

  // Monitor: compare each read against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (sb_q.size() == 0) begin
        chk("scoreboard empty", bus_rdata, 32'hx);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, bus_rdata, e.v);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      dir_m[b] = '1;
      lat_m[b] = '0;
      in_m[b]  = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_pins("R1 reset");
    bus_op(0, 1, addr_of(0, 0), 0, "R1 dir bank0 after reset");
    bus_op(0, 1, addr_of(4, 1), 0, "R1 latch bank4 after reset");

    // R2 direction and output enable
    bus_op(1, 0, addr_of(0, 0), 32'h0000FFFF, "");
    idle();
    chk_pins("R2 dir write");
    bus_op(0, 1, addr_of(0, 0), 0, "R2 dir readback");

    // R3 output data replace
    bus_op(1, 0, addr_of(0, 1), 32'h12345678, "");
    idle();
    chk_pins("R3 out write");
    bus_op(0, 1, addr_of(0, 1), 0, "R3 out readback");

    // R4 set port, R6 read via set port
    bus_op(1, 0, addr_of(0, 2), 32'h80000001, "");
    bus_op(0, 1, addr_of(0, 2), 0, "R4 R6 set then read set port");
    bus_op(1, 0, addr_of(0, 2), 32'h0, "");
    bus_op(0, 1, addr_of(0, 1), 0, "R4 set with zero leaves latch");

    // R5 clear port, R6 read via clear port
    bus_op(1, 0, addr_of(0, 3), 32'h00000078, "");
    bus_op(0, 1, addr_of(0, 3), 0, "R5 R6 clear then read clear port");
    idle();
    chk_pins("R5 clear");

    // R8 bank separation and placement
    bus_op(1, 0, addr_of(4, 1), 32'hCAFEF00D, "");
    bus_op(1, 0, addr_of(2, 0), 32'h0F0F0F0F, "");
    idle();
    chk_pins("R8 bank4 and bank2");
    bus_op(0, 1, addr_of(2, 1), 0, "R8 bank2 latch untouched");
    bus_op(0, 1, addr_of(4, 1), 0, "R8 bank4 latch");

    // R9 unmapped writes ignored, reads zero
    bus_op(1, 1, 4,               32'hFFFFFFFF, "R9 below base");
    bus_op(1, 1, addr_of(0, 5),   32'hFFFFFFFF, "R9 interrupt word");
    bus_op(1, 1, addr_of(1, 9),   32'hFFFFFFFF, "R9 last word of block");
    bus_op(1, 1, addr_of(0, 1)+1, 32'hFFFFFFFF, "R9 misaligned");
    bus_op(1, 1, addr_of(5, 1),   32'hFFFFFFFF, "R9 bank beyond count");
    idle();
    chk_pins("R9 state after unmapped writes");

    // R10 read and write in the same cycle
    bus_op(1, 0, addr_of(1, 1), 32'hAAAA5555, "");
    bus_op(1, 1, addr_of(1, 1), 32'h13572468, "R10 same cycle returns old");
    bus_op(0, 1, addr_of(1, 1), 0, "R10 next read returns new");

    // R7 input synchronizer latency
    bus_op(0, 1, addr_of(3, 4), 0, "R7 old level same cycle");
    pin_in[3*32 +: 32] = 32'hA5A5C3C3;
    bus_op(0, 1, addr_of(3, 4), 0, "R7 old level after one edge");
    in_m[3] = 32'hA5A5C3C3;
    bus_op(0, 1, addr_of(3, 4), 0, "R7 new level after two edges");

    // R7 pins driven as outputs still read back
    idle();
    pin_in[31:0] = lat_m[0];
    in_m[0] = lat_m[0];
    idle();
    bus_op(0, 1, addr_of(0, 4), 0, "R7 loopback of output pins");
    idle();

    repeat (3) @(posedge clk);
    chk("scoreboard drained R10", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule